// File: doc/BRIEF.md
# Invalid-Opcode Fault Detection Unit

This unit sits next to an instruction decoder and decides, for each dispatched instruction, whether it has to raise the invalid-opcode fault (vector 6). Several separate checks feed that decision. They cover reserved and malformed encodings, the dedicated always-undefined instruction, and the SIMD gating by control bits and feature flags. They also cover illegal LOCK usage and instructions that are illegal in the current operating mode. Each check honours its own exemption set. The decoder supplies the class signals and the exemption-membership flags. The unit applies the control bits, feature words and mode.

The decision is not signalled at dispatch. Every dispatched instruction enters an in-order queue of eight entries, together with its tag, its instruction pointer and its candidate fault bit. The fault appears only when that entry retires at the head of the queue. A flush discards every entry younger than the flush tag, so an instruction that is speculative or was only prefetched never signals. The reported pointer is the pointer of the faulting instruction itself. No error code is produced.

Tags must be handed out sequentially, modulo 2^TAG_W. After a flush, the next dispatch carries the flush tag plus one.

Top module: `ud_fault_unit`

## Requirements
- R1: An instruction marked reserved by the decoder, or marked as having an operand type that is illegal for its opcode, is classified as faulting.
- R2: A reserved instruction whose primary one-byte opcode (op_primary=1) is 0xD6 or 0xF1 does not fault. The same byte values outside the primary map (op_primary=0) still fault.
- R3: The dedicated undefined instruction (op_ud2=1) always faults, and fault_ip equals the dispatch_ip of that same instruction.
- R4: With ctl_fpu_emul=1, any instruction with simd_kind 1..5 faults unless simd_em_exempt=1. The simd_kind codes are 1 packed-integer, 2 SIMD-1, 3 SIMD-2, 4 SIMD-3 and 5 supplemental SIMD-3.
- R5: With ctl_os_fxsave=0, an instruction with simd_kind 2..5 faults unless simd_fxsr_exempt=1. An instruction with simd_kind 1 is not affected by this bit.
- R6: An instruction with simd_kind 2..5 that reports simd_fp_exc=1 faults when ctl_os_simd_exc=0, and does not fault on that account when ctl_os_simd_exc=1.
- R7: An instruction faults when its feature flag is 0. The flags are feat_word0 bit 23 for kind 1, bit 25 for kind 2 and bit 26 for kind 3, and feat_word1 bit 0 for kind 4 and bit 9 for kind 5.
- R8: lock_prefix=1 faults when op_lockable=0, or when op_lockable=1 and dest_is_mem=0. A locked, lockable instruction with a memory destination does not fault.
- R9: op_sys_seg=1 faults in cpu_mode 0 (real) or 1 (virtual-8086) and not in 2 (protected). op_rsm=1 faults in every mode except 3 (system-management).
- R10: fault_valid is high only in a cycle where retire_valid is high and retire_tag equals the oldest queued tag whose entry is faulting. fault_vector is then 6. A faulting entry that is not retired never raises fault_valid.
- R11: flush_valid removes every queued entry younger than flush_tag and keeps flush_tag's own entry. A dispatch in the same cycle is dropped. A flushed faulting entry never raises fault_valid.
- R12: After a synchronous active-low reset the queue is empty, queue_full is 0 and fault_valid is 0.
- R13: queue_full is 1 when eight entries are held. A dispatch while full is discarded, and its fault never appears.
- R14: A retire whose tag does not match the oldest entry is ignored. It raises no fault and leaves the oldest entry in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dispatch_valid | input | 1 | An instruction enters the queue |
| dispatch_tag | input | TAG_W | Sequential tag of the dispatched instruction |
| dispatch_ip | input | IP_W | Instruction pointer of the dispatched instruction |
| op_primary | input | 1 | Opcode comes from the primary one-byte map |
| op_byte | input | 8 | Primary opcode byte |
| op_reserved | input | 1 | Decoder found a reserved/undefined encoding |
| op_bad_operand | input | 1 | Operand type illegal for the opcode |
| op_ud2 | input | 1 | Dedicated undefined instruction |
| simd_kind | input | 3 | SIMD family code (0 none, 1..5 as in R4) |
| simd_em_exempt | input | 1 | Instruction is exempt from the emulation check |
| simd_fxsr_exempt | input | 1 | Instruction is exempt from the OS-save-support check |
| simd_fp_exc | input | 1 | Instruction produced a SIMD floating-point exception |
| lock_prefix | input | 1 | LOCK prefix present |
| op_lockable | input | 1 | Opcode may be locked |
| dest_is_mem | input | 1 | Destination operand is memory |
| op_sys_seg | input | 1 | Descriptor/task/limit/rights/verify/privilege-adjust class |
| op_rsm | input | 1 | Resume-from-system-management instruction |
| ctl_fpu_emul | input | 1 | FPU emulation control bit |
| ctl_os_fxsave | input | 1 | OS supports extended state save |
| ctl_os_simd_exc | input | 1 | OS handles SIMD floating-point exceptions |
| feat_word0 | input | FEAT_W | First feature word |
| feat_word1 | input | FEAT_W | Second feature word |
| cpu_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected, 3 system-management |
| retire_valid | input | 1 | Retire handshake |
| retire_tag | input | TAG_W | Tag being retired |
| flush_valid | input | 1 | Pipeline flush |
| flush_tag | input | TAG_W | Youngest surviving tag |
| queue_full | output | 1 | Eight entries held |
| fault_valid | output | 1 | Invalid-opcode fault reported this cycle |
| fault_vector | output | 8 | 6 while fault_valid, else 0 |
| fault_ip | output | IP_W | Saved instruction pointer while fault_valid, else 0 |

## Verification
Classification is captured at the dispatch edge. It becomes visible only at retirement, and the fault outputs are combinational from the retire inputs, so a result is due in the same cycle as the retire handshake, zero edges after it is driven. The bench drives each handshake just after a rising edge and the monitor compares at the following falling edge, popping the expected entry queued by the driver. Flush, full and queue_full effects take one edge, so those checks sample at the falling edge one cycle after the stimulus. Cycles without a retire are watched for any stray fault pulse.

// File: rtl/ud_pkg.sv
// Shared types and constants for the invalid-opcode fault unit.
// Assumes the feature words are at least 27 bits wide.
package ud_pkg;

    localparam logic [7:0] UD_VECTOR = 8'd6;

    // Feature-flag bit positions inside the two feature words.
    localparam int FEAT0_PKINT_BIT = 23;
    localparam int FEAT0_SIMD1_BIT = 25;
    localparam int FEAT0_SIMD2_BIT = 26;
    localparam int FEAT1_SIMD3_BIT = 0;
    localparam int FEAT1_SSIMD3_BIT = 9;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_PKINT  = 3'd1,
        KIND_SIMD1  = 3'd2,
        KIND_SIMD2  = 3'd3,
        KIND_SIMD3  = 3'd4,
        KIND_SSIMD3 = 3'd5
    } simd_kind_e;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_V86  = 2'd1,
        MODE_PROT = 2'd2,
        MODE_SMM  = 2'd3
    } cpu_mode_e;

    typedef struct packed {
        logic       primary;
        logic [7:0] opbyte;
        logic       reserved;
        logic       bad_operand;
        logic       ud2;
        simd_kind_e kind;
        logic       em_exempt;
        logic       fxsr_exempt;
        logic       fp_exc;
        logic       lock;
        logic       lockable;
        logic       dest_mem;
        logic       sys_seg;
        logic       rsm;
    } ud_decode_t;

endpackage

// File: rtl/ud_rule_check.sv
// Combinational classifier: merges every invalid-opcode rule into one
// candidate fault bit. Assumes the decoder already decided membership in
// each exemption set and passes it as a flag.
module ud_rule_check
    import ud_pkg::*;
#(
    parameter int FEAT_W = 32
) (
    input  ud_decode_t        dec,
    input  logic              ctl_fpu_emul,
    input  logic              ctl_os_fxsave,
    input  logic              ctl_os_simd_exc,
    input  logic [FEAT_W-1:0] feat_word0,
    input  logic [FEAT_W-1:0] feat_word1,
    input  cpu_mode_e         mode,
    output logic              fault
);

    logic is_simd;
    logic is_sse;
    logic feat_ok;
    logic r_reserved;
    logic r_operand;
    logic r_emul;
    logic r_fxsave;
    logic r_simd_exc;
    logic r_feature;
    logic r_lock;
    logic r_mode;

    // Family membership and the feature flag that enables the family.
    always_comb begin
        is_simd = 1'b0;
        is_sse  = 1'b0;
        feat_ok = 1'b1;
        case (dec.kind)
            KIND_PKINT:  begin is_simd = 1'b1; feat_ok = feat_word0[FEAT0_PKINT_BIT]; end
            KIND_SIMD1:  begin is_simd = 1'b1; is_sse = 1'b1; feat_ok = feat_word0[FEAT0_SIMD1_BIT]; end
            KIND_SIMD2:  begin is_simd = 1'b1; is_sse = 1'b1; feat_ok = feat_word0[FEAT0_SIMD2_BIT]; end
            KIND_SIMD3:  begin is_simd = 1'b1; is_sse = 1'b1; feat_ok = feat_word1[FEAT1_SIMD3_BIT]; end
            KIND_SSIMD3: begin is_simd = 1'b1; is_sse = 1'b1; feat_ok = feat_word1[FEAT1_SSIMD3_BIT]; end
            default:     begin is_simd = 1'b0; is_sse = 1'b0; feat_ok = 1'b1; end
        endcase
    end

    // Each individual rule, then their union.
    always_comb begin
        r_reserved = dec.reserved &&
                     !(dec.primary && (dec.opbyte == 8'hD6 || dec.opbyte == 8'hF1));
        r_operand  = dec.bad_operand;
        r_emul     = ctl_fpu_emul && is_simd && !dec.em_exempt;
        r_fxsave   = !ctl_os_fxsave && is_sse && !dec.fxsr_exempt;
        r_simd_exc = is_sse && dec.fp_exc && !ctl_os_simd_exc;
        r_feature  = is_simd && !feat_ok;
        r_lock     = dec.lock && (!dec.lockable || !dec.dest_mem);
        r_mode     = (dec.sys_seg && (mode == MODE_REAL || mode == MODE_V86)) ||
                     (dec.rsm && mode != MODE_SMM);
        fault      = dec.ud2 | r_reserved | r_operand | r_emul | r_fxsave |
                     r_simd_exc | r_feature | r_lock | r_mode;
    end

endmodule

// File: rtl/ud_retire_queue.sv
// In-order queue of dispatched instructions with their candidate fault.
// Assumes DEPTH is a power of two, TAG_W > log2(DEPTH), and tags are
// dispatched sequentially so a tag's age equals its offset from the head.
module ud_retire_queue #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4,
    parameter int IP_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_valid,
    input  logic [TAG_W-1:0]              push_tag,
    input  logic [IP_W-1:0]               push_ip,
    input  logic                          push_fault,
    input  logic                          retire_valid,
    input  logic [TAG_W-1:0]              retire_tag,
    input  logic                          flush_valid,
    input  logic [TAG_W-1:0]              flush_tag,
    output logic                          retire_hit,
    output logic                          head_fault,
    output logic [IP_W-1:0]               head_ip,
    output logic [$clog2(DEPTH):0]        count,
    output logic                          full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int CW    = (TAG_W > CNT_W) ? TAG_W : CNT_W;

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [IP_W-1:0]  ip_q  [DEPTH];
    logic             flt_q [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] keep_cnt;
    logic [CNT_W-1:0] cnt_n;
    logic [TAG_W-1:0] flush_off;
    logic             push;

    // Retire match, flush truncation, accept decision and next occupancy.
    always_comb begin
        retire_hit = retire_valid && (cnt_q != '0) && (retire_tag == tag_q[head_q]);
        flush_off  = flush_tag - tag_q[head_q];
        keep_cnt   = cnt_q;
        if (flush_valid && (CW'(flush_off) < CW'(cnt_q))) begin
            keep_cnt = CNT_W'(flush_off) + CNT_W'(1);
        end
        push   = push_valid && !flush_valid && (cnt_q != CNT_W'(DEPTH));
        wr_ptr = head_q + cnt_q[PTR_W-1:0];
        cnt_n  = keep_cnt - CNT_W'(retire_hit) + CNT_W'(push);
    end

    // Entry storage: write the slot just past the youngest entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                tag_q[i] <= '0;
                ip_q[i]  <= '0;
                flt_q[i] <= 1'b0;
            end else if (push && (wr_ptr == PTR_W'(i))) begin
                tag_q[i] <= push_tag;
                ip_q[i]  <= push_ip;
                flt_q[i] <= push_fault;
            end
        end
    end

    // Head pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= head_q + PTR_W'(retire_hit);
            cnt_q  <= cnt_n;
        end
    end

    assign head_fault = flt_q[head_q];
    assign head_ip    = ip_q[head_q];
    assign count      = cnt_q;
    assign full       = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/ud_fault_unit.sv
// Top of the invalid-opcode fault unit: classifies each dispatched
// instruction and reports vector 6 only when the faulting entry retires.
// Assumes sequential tags and at most one dispatch/retire/flush per cycle.
module ud_fault_unit
    import ud_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 4,
    parameter int IP_W   = 32,
    parameter int FEAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dispatch_valid,
    input  logic [TAG_W-1:0]  dispatch_tag,
    input  logic [IP_W-1:0]   dispatch_ip,
    input  logic              op_primary,
    input  logic [7:0]        op_byte,
    input  logic              op_reserved,
    input  logic              op_bad_operand,
    input  logic              op_ud2,
    input  logic [2:0]        simd_kind,
    input  logic              simd_em_exempt,
    input  logic              simd_fxsr_exempt,
    input  logic              simd_fp_exc,
    input  logic              lock_prefix,
    input  logic              op_lockable,
    input  logic              dest_is_mem,
    input  logic              op_sys_seg,
    input  logic              op_rsm,
    input  logic              ctl_fpu_emul,
    input  logic              ctl_os_fxsave,
    input  logic              ctl_os_simd_exc,
    input  logic [FEAT_W-1:0] feat_word0,
    input  logic [FEAT_W-1:0] feat_word1,
    input  logic [1:0]        cpu_mode,
    input  logic              retire_valid,
    input  logic [TAG_W-1:0]  retire_tag,
    input  logic              flush_valid,
    input  logic [TAG_W-1:0]  flush_tag,
    output logic              queue_full,
    output logic              fault_valid,
    output logic [7:0]        fault_vector,
    output logic [IP_W-1:0]   fault_ip
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    ud_decode_t       dec;
    logic             cand_fault;
    logic             retire_hit;
    logic             head_fault;
    logic [IP_W-1:0]  head_ip;
    logic [CNT_W-1:0] q_count;

    // Gather the decoder's loose signals into one record.
    always_comb begin
        dec.primary     = op_primary;
        dec.opbyte      = op_byte;
        dec.reserved    = op_reserved;
        dec.bad_operand = op_bad_operand;
        dec.ud2         = op_ud2;
        dec.kind        = simd_kind_e'(simd_kind);
        dec.em_exempt   = simd_em_exempt;
        dec.fxsr_exempt = simd_fxsr_exempt;
        dec.fp_exc      = simd_fp_exc;
        dec.lock        = lock_prefix;
        dec.lockable    = op_lockable;
        dec.dest_mem    = dest_is_mem;
        dec.sys_seg     = op_sys_seg;
        dec.rsm         = op_rsm;
    end

    ud_rule_check #(.FEAT_W(FEAT_W)) u_rules (
        .dec             (dec),
        .ctl_fpu_emul    (ctl_fpu_emul),
        .ctl_os_fxsave   (ctl_os_fxsave),
        .ctl_os_simd_exc (ctl_os_simd_exc),
        .feat_word0      (feat_word0),
        .feat_word1      (feat_word1),
        .mode            (cpu_mode_e'(cpu_mode)),
        .fault           (cand_fault)
    );

    ud_retire_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IP_W(IP_W)) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid   (dispatch_valid),
        .push_tag     (dispatch_tag),
        .push_ip      (dispatch_ip),
        .push_fault   (cand_fault),
        .retire_valid (retire_valid),
        .retire_tag   (retire_tag),
        .flush_valid  (flush_valid),
        .flush_tag    (flush_tag),
        .retire_hit   (retire_hit),
        .head_fault   (head_fault),
        .head_ip      (head_ip),
        .count        (q_count),
        .full         (queue_full)
    );

    // Fault report coincides with the retire handshake of the head entry.
    assign fault_valid  = retire_hit & head_fault;
    assign fault_vector = fault_valid ? UD_VECTOR : 8'd0;
    assign fault_ip     = fault_valid ? head_ip : '0;

endmodule

// File: rtl/ud_fault_checker.sv
// Property checker for ud_fault_unit, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module ud_fault_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dispatch_valid,
    input logic             retire_valid,
    input logic             flush_valid,
    input logic             queue_full,
    input logic             fault_valid,
    input logic [7:0]       fault_vector,
    input logic [CNT_W-1:0] count
);

    // R10: a fault is only ever reported alongside a retire handshake.
    assert_fault_needs_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> retire_valid);

    // R10: the reported vector is the invalid-opcode vector.
    assert_vector_six_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> fault_vector == 8'd6);

    // R11: a flush never grows the queue.
    assert_flush_no_growth_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> count <= $past(count));

    // R12: reset leaves the queue empty.
    assert_reset_empty_R12: assert property (@(posedge clk)
        !rst_n |=> count == '0);

    // R13: occupancy never exceeds the depth.
    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R13: a full queue with no retire or flush stays full despite dispatch.
    assert_full_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_full && dispatch_valid && !retire_valid && !flush_valid) |=> queue_full);

endmodule

bind ud_fault_unit ud_fault_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_ud_fault_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .dispatch_valid (dispatch_valid),
    .retire_valid   (retire_valid),
    .flush_valid    (flush_valid),
    .queue_full     (queue_full),
    .fault_valid    (fault_valid),
    .fault_vector   (fault_vector),
    .count          (q_count)
);

// File: tb/test_ud_fault_unit.sv
// Scoreboard bench: driver tasks queue expected retire results, a monitor
// on the falling edge pops and compares them against the fault outputs.
module test_ud_fault_unit;

    localparam int TAG_W  = 4;
    localparam int IP_W   = 32;
    localparam int FEAT_W = 32;
    localparam int DEPTH  = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              dispatch_valid = 1'b0;
    logic [TAG_W-1:0]  dispatch_tag = '0;
    logic [IP_W-1:0]   dispatch_ip = '0;
    logic              op_primary = 1'b0;
    logic [7:0]        op_byte = 8'h90;
    logic              op_reserved = 1'b0;
    logic              op_bad_operand = 1'b0;
    logic              op_ud2 = 1'b0;
    logic [2:0]        simd_kind = 3'd0;
    logic              simd_em_exempt = 1'b0;
    logic              simd_fxsr_exempt = 1'b0;
    logic              simd_fp_exc = 1'b0;
    logic              lock_prefix = 1'b0;
    logic              op_lockable = 1'b0;
    logic              dest_is_mem = 1'b0;
    logic              op_sys_seg = 1'b0;
    logic              op_rsm = 1'b0;
    logic              ctl_fpu_emul = 1'b0;
    logic              ctl_os_fxsave = 1'b1;
    logic              ctl_os_simd_exc = 1'b1;
    logic [FEAT_W-1:0] feat_word0 = '1;
    logic [FEAT_W-1:0] feat_word1 = '1;
    logic [1:0]        cpu_mode = 2'd2;
    logic              retire_valid = 1'b0;
    logic [TAG_W-1:0]  retire_tag = '0;
    logic              flush_valid = 1'b0;
    logic [TAG_W-1:0]  flush_tag = '0;
    logic              queue_full;
    logic              fault_valid;
    logic [7:0]        fault_vector;
    logic [IP_W-1:0]   fault_ip;

    ud_fault_unit #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IP_W(IP_W), .FEAT_W(FEAT_W)) i_ud_fault_unit (
        .clk(clk), .rst_n(rst_n),
        .dispatch_valid(dispatch_valid), .dispatch_tag(dispatch_tag), .dispatch_ip(dispatch_ip),
        .op_primary(op_primary), .op_byte(op_byte), .op_reserved(op_reserved),
        .op_bad_operand(op_bad_operand), .op_ud2(op_ud2), .simd_kind(simd_kind),
        .simd_em_exempt(simd_em_exempt), .simd_fxsr_exempt(simd_fxsr_exempt),
        .simd_fp_exc(simd_fp_exc), .lock_prefix(lock_prefix), .op_lockable(op_lockable),
        .dest_is_mem(dest_is_mem), .op_sys_seg(op_sys_seg), .op_rsm(op_rsm),
        .ctl_fpu_emul(ctl_fpu_emul), .ctl_os_fxsave(ctl_os_fxsave),
        .ctl_os_simd_exc(ctl_os_simd_exc), .feat_word0(feat_word0), .feat_word1(feat_word1),
        .cpu_mode(cpu_mode), .retire_valid(retire_valid), .retire_tag(retire_tag),
        .flush_valid(flush_valid), .flush_tag(flush_tag), .queue_full(queue_full),
        .fault_valid(fault_valid), .fault_vector(fault_vector), .fault_ip(fault_ip)
    );

    typedef struct {
        logic       primary;
        logic [7:0] opbyte;
        logic       reserved;
        logic       bad;
        logic       ud2;
        logic [2:0] kind;
        logic       em_ex;
        logic       fx_ex;
        logic       fpx;
        logic       lock;
        logic       lockable;
        logic       dmem;
        logic       sysseg;
        logic       rsm;
    } instr_t;

    typedef struct {
        logic [TAG_W-1:0] tag;
        bit               fault;
        logic [IP_W-1:0]  ip;
        string            req;
    } exp_t;

    exp_t             exp_q[$];
    int               n_chk = 0;
    int               n_bad = 0;
    logic [TAG_W-1:0] next_tag = '0;
    string            stray_req = "R14";
    bit               started = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic instr_t plain();
        instr_t d;
        d.primary = 1'b1; d.opbyte = 8'h90; d.reserved = 1'b0; d.bad = 1'b0;
        d.ud2 = 1'b0; d.kind = 3'd0; d.em_ex = 1'b0; d.fx_ex = 1'b0; d.fpx = 1'b0;
        d.lock = 1'b0; d.lockable = 1'b0; d.dmem = 1'b0; d.sysseg = 1'b0; d.rsm = 1'b0;
        return d;
    endfunction

    function automatic instr_t undef();
        instr_t d;
        d = plain();
        d.ud2 = 1'b1;
        return d;
    endfunction

    task automatic clear_drive();
        dispatch_valid = 1'b0;
        retire_valid   = 1'b0;
        flush_valid    = 1'b0;
    endtask

    task automatic drive_fields(input instr_t d);
        op_primary = d.primary; op_byte = d.opbyte; op_reserved = d.reserved;
        op_bad_operand = d.bad; op_ud2 = d.ud2; simd_kind = d.kind;
        simd_em_exempt = d.em_ex; simd_fxsr_exempt = d.fx_ex; simd_fp_exc = d.fpx;
        lock_prefix = d.lock; op_lockable = d.lockable; dest_is_mem = d.dmem;
        op_sys_seg = d.sysseg; op_rsm = d.rsm;
    endtask

    // Driver: dispatch one instruction and queue its expected retire result.
    task automatic dispatch(input instr_t d, input bit f, input string req, input bit accepted);
        exp_t e;
        @(posedge clk); #1;
        clear_drive();
        drive_fields(d);
        dispatch_valid = 1'b1;
        dispatch_tag   = next_tag;
        dispatch_ip    = 32'h4000_0000 + 32'(next_tag) * 32'd4;
        if (accepted) begin
            e.tag = next_tag; e.fault = f; e.ip = dispatch_ip; e.req = req;
            exp_q.push_back(e);
            next_tag = next_tag + TAG_W'(1);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            clear_drive();
        end
    endtask

    task automatic retire_t(input logic [TAG_W-1:0] t);
        @(posedge clk); #1;
        clear_drive();
        retire_valid = 1'b1;
        retire_tag   = t;
    endtask

    task automatic retire_head();
        retire_t(exp_q[0].tag);
    endtask

    task automatic run_one(input instr_t d, input bit f, input string req);
        dispatch(d, f, req, 1'b1);
        retire_head();
    endtask

    // Flush keeping tag t; optionally a faulting dispatch in the same cycle.
    task automatic flush_at(input logic [TAG_W-1:0] t, input bit with_dispatch);
        @(posedge clk); #1;
        clear_drive();
        flush_valid = 1'b1;
        flush_tag   = t;
        if (with_dispatch) begin
            drive_fields(undef());
            dispatch_valid = 1'b1;
            dispatch_tag   = next_tag;
            dispatch_ip    = 32'h5000_0000;
        end
        while (exp_q.size() > 0 && exp_q[$].tag != t) void'(exp_q.pop_back());
        next_tag = t + TAG_W'(1);
    endtask

    // Monitor: compare results due in the cycle of each retire handshake.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && started) begin
            if (retire_valid) begin
                if (exp_q.size() > 0 && exp_q[0].tag == retire_tag) begin
                    e = exp_q.pop_front();
                    check(fault_valid == e.fault, e.req, "fault_valid", fault_valid, e.fault);
                    if (e.fault) begin
                        check(fault_ip == e.ip, e.req, "fault_ip", fault_ip, e.ip);
                        check(fault_vector == 8'd6, e.req, "fault_vector", fault_vector, 6);
                    end
                end else begin
                    check(fault_valid == 1'b0, stray_req, "fault on unmatched retire", fault_valid, 0);
                end
            end else if (fault_valid) begin
                check(1'b0, "R10", "fault_valid without retire", 1, 0);
            end
        end
    end

    initial begin
        instr_t d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(queue_full == 1'b0, "R12", "queue_full in reset", queue_full, 0);
        check(fault_valid == 1'b0, "R12", "fault_valid in reset", fault_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        started = 1'b1;

        // R1: reserved encoding, illegal operand, and a clean instruction.
        run_one(plain(), 1'b0, "R1");
        d = plain(); d.opbyte = 8'h82; d.reserved = 1'b1; run_one(d, 1'b1, "R1");
        d = plain(); d.bad = 1'b1; run_one(d, 1'b1, "R1");

        // R2: D6/F1 exemption only in the primary map.
        d = plain(); d.opbyte = 8'hD6; d.reserved = 1'b1; run_one(d, 1'b0, "R2");
        d = plain(); d.opbyte = 8'hF1; d.reserved = 1'b1; run_one(d, 1'b0, "R2");
        d = plain(); d.opbyte = 8'hD6; d.reserved = 1'b1; d.primary = 1'b0; run_one(d, 1'b1, "R2");

        // R3: dedicated undefined instruction, pointer checked by monitor.
        run_one(undef(), 1'b1, "R3");

        // R4: FPU-emulation bit.
        ctl_fpu_emul = 1'b1;
        d = plain(); d.kind = 3'd3; run_one(d, 1'b1, "R4");
        d = plain(); d.kind = 3'd1; d.em_ex = 1'b1; run_one(d, 1'b0, "R4");
        d = plain(); d.kind = 3'd1; run_one(d, 1'b1, "R4");
        idle(1); ctl_fpu_emul = 1'b0;

        // R5: OS extended-save support bit.
        ctl_os_fxsave = 1'b0;
        d = plain(); d.kind = 3'd2; run_one(d, 1'b1, "R5");
        d = plain(); d.kind = 3'd2; d.fx_ex = 1'b1; run_one(d, 1'b0, "R5");
        d = plain(); d.kind = 3'd1; run_one(d, 1'b0, "R5");
        idle(1); ctl_os_fxsave = 1'b1;

        // R6: SIMD floating-point exception gating.
        d = plain(); d.kind = 3'd4; d.fpx = 1'b1; run_one(d, 1'b0, "R6");
        ctl_os_simd_exc = 1'b0;
        run_one(d, 1'b1, "R6");
        idle(1); ctl_os_simd_exc = 1'b1;

        // R7: feature flags.
        feat_word0[23] = 1'b0;
        d = plain(); d.kind = 3'd1; run_one(d, 1'b1, "R7");
        idle(1); feat_word0 = '1; feat_word0[26] = 1'b0;
        d = plain(); d.kind = 3'd3; run_one(d, 1'b1, "R7");
        d = plain(); d.kind = 3'd2; run_one(d, 1'b0, "R7");
        idle(1); feat_word0 = '1; feat_word1[0] = 1'b0;
        d = plain(); d.kind = 3'd4; run_one(d, 1'b1, "R7");
        idle(1); feat_word1 = '1; feat_word1[9] = 1'b0;
        d = plain(); d.kind = 3'd5; run_one(d, 1'b1, "R7");
        idle(1); feat_word1 = '1;

        // R8: LOCK prefix.
        d = plain(); d.lock = 1'b1; run_one(d, 1'b1, "R8");
        d.lockable = 1'b1; run_one(d, 1'b1, "R8");
        d.dmem = 1'b1; run_one(d, 1'b0, "R8");

        // R9: mode-dependent instructions.
        d = plain(); d.sysseg = 1'b1;
        cpu_mode = 2'd0; run_one(d, 1'b1, "R9");
        idle(1); cpu_mode = 2'd1; run_one(d, 1'b1, "R9");
        idle(1); cpu_mode = 2'd2; run_one(d, 1'b0, "R9");
        d = plain(); d.rsm = 1'b1; run_one(d, 1'b1, "R9");
        idle(1); cpu_mode = 2'd3; run_one(d, 1'b0, "R9");
        idle(1); cpu_mode = 2'd2;

        // R10: no report until retire; pulse lasts only the retire cycle.
        dispatch(undef(), 1'b1, "R10", 1'b1);
        idle(4);
        @(negedge clk);
        check(fault_valid == 1'b0, "R10", "fault before retire", fault_valid, 0);
        retire_head();
        idle(1);
        @(negedge clk);
        check(fault_valid == 1'b0, "R10", "fault after retire", fault_valid, 0);

        // R14: mismatched retire ignored, head then retires normally.
        dispatch(undef(), 1'b1, "R14", 1'b1);
        stray_req = "R14";
        retire_t(exp_q[0].tag + TAG_W'(1));
        retire_head();

        // R11: flush younger entries and a same-cycle dispatch.
        begin
            logic [TAG_W-1:0] t0;
            t0 = next_tag;
            for (int k = 0; k < 4; k++) dispatch(undef(), 1'b1, "R11", 1'b1);
            flush_at(t0 + TAG_W'(1), 1'b1);
            retire_head();
            retire_head();
            stray_req = "R11";
            retire_t(t0 + TAG_W'(2));
            retire_t(t0 + TAG_W'(3));
            stray_req = "R14";
        end

        // R13: full queue rejects a dispatch.
        for (int k = 0; k < DEPTH; k++) begin
            if (k % 2 == 0) dispatch(undef(), 1'b1, "R13", 1'b1);
            else dispatch(plain(), 1'b0, "R13", 1'b1);
        end
        idle(1);
        @(negedge clk);
        check(queue_full == 1'b1, "R13", "queue_full at eight", queue_full, 1);
        dispatch(undef(), 1'b1, "R13", 1'b0);
        idle(1);
        @(negedge clk);
        check(queue_full == 1'b1, "R13", "queue_full after rejected dispatch", queue_full, 1);
        for (int k = 0; k < DEPTH; k++) retire_head();
        stray_req = "R13";
        retire_t(next_tag);
        idle(1);
        @(negedge clk);
        check(queue_full == 1'b0, "R13", "queue_full after drain", queue_full, 0);
        idle(2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule